// File: doc/BRIEF.md
# Packed Byte Saturating Adder

This block treats each of its two 32-bit input words as four signed 8-bit lanes and adds matching lanes side by side. Each lane works out its true sum at 9 bits, so nothing overflows inside the adder, and then clamps that sum into the signed byte range. The four clamped bytes go back into one 32-bit result word. A 4-bit flag vector is built alongside it, with one bit for each lane, and a bit is set only when its lane stayed in range.

An execute stage uses the block. The stage presents both operands with a valid strobe and a qualifier that says whether the operation is allowed to commit. The result, flags and output valid are all registered and appear one clock after the input valid. When the qualifier is low, the stored result and flags do not change.

Top module: `pbsat_add`

## Requirements
- R1: Lane i takes bits [8i+7:8i] of each operand and writes bits [8i+7:8i] of the result. It also drives flag bit i.
- R2: The lane sum is formed from the two sign-extended 9-bit operands. When the sum lies between -128 and +127, the result byte is the low 8 bits of that sum.
- R3: A lane whose sum is above +127 returns 0x7F.
- R4: A lane whose sum is below -128 returns 0x80.
- R5: A flag bit is 0 when its lane saturated in either direction and 1 otherwise.
- R6: A lane's carry or saturation has no effect on the result byte or flag of any other lane.
- R7: If in_valid is high and cond_pass is low, the result and flags keep their previous values.
- R8: out_valid is high exactly one cycle after in_valid was high. When that update committed, the result and flags show that operation.
- R9: A synchronous active-low reset clears the result and flags to zero and drops out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands valid |
| cond_pass | input | 1 | Commit qualifier |
| op_a | input | 32 | First packed operand |
| op_b | input | 32 | Second packed operand |
| res | output | 32 | Packed clamped result |
| lane_ok | output | 4 | Per-lane non-saturation flags |
| out_valid | output | 1 | Result valid, one cycle after in_valid |

## Verification
The directed sums 0x7F+0x01 and 0x7F+0x7F are used to separate positive clamping from wraparound. The sums 0x80+0xFF and 0x80+0x80 do the same for negative clamping. Vectors in which each lane carries a different case (overflow, underflow, exact boundary, in range) expose any leak of carry or flag between lanes. Random operand pairs, some of them with cond_pass low, check the hold behaviour and the general arithmetic against a bench model.

// File: rtl/pbsat_pkg.sv
// Package: shared lane geometry for the packed saturating adder.
// Assumes lanes are equal width and the data word is a multiple of the lane width.
package pbsat_pkg;
    localparam int LANE_W  = 8;
    localparam int LANES   = 4;
    localparam int WORD_W  = LANE_W * LANES;

    // Result of one lane: clamped byte plus non-saturation flag.
    typedef struct packed {
        logic [LANE_W-1:0] val;
        logic              ok;
    } lane_res_t;
endpackage

// File: rtl/pbsat_lane.sv
// Module: one signed lane with saturation.
// Sign-extends both operands by one bit and adds them. If the sum falls outside the
// signed range, it is clamped to the nearest bound. Purely combinational.
module pbsat_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         ok
);
    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic [W:0] sum;

    // Wide sum and clamp decision.
    always_comb begin
        sum = {a[W-1], a} + {b[W-1], b};
        // The top two sum bits disagree exactly when the result is out of range.
        if (sum[W] == sum[W-1]) begin
            y  = sum[W-1:0];
            ok = 1'b1;
        end else if (sum[W]) begin
            y  = MINV;
            ok = 1'b0;
        end else begin
            y  = MAXV;
            ok = 1'b0;
        end
    end
endmodule

// File: rtl/pbsat_add.sv
// Module: top of the packed saturating adder.
// Instantiates one lane per byte, then registers the result, the flags and the
// output valid. The result and flags load only on in_valid && cond_pass.
// Assumes synchronous active-low reset.
module pbsat_add
    import pbsat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              cond_pass,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic [WORD_W-1:0] res,
    output logic [LANES-1:0]  lane_ok,
    output logic              out_valid
);
    logic [WORD_W-1:0] res_d;
    logic [LANES-1:0]  ok_d;
    logic              commit;

    genvar gi;
    generate
        for (gi = 0; gi < LANES; gi++) begin : g_lane
            pbsat_lane #(.W(LANE_W)) u_lane (
                .a  (op_a[gi*LANE_W +: LANE_W]),
                .b  (op_b[gi*LANE_W +: LANE_W]),
                .y  (res_d[gi*LANE_W +: LANE_W]),
                .ok (ok_d[gi])
            );
        end
    endgenerate

    assign commit = in_valid && cond_pass;

    // Output valid follows the input strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Result and flag registers load only on a committed operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res     <= '0;
            lane_ok <= '0;
        end else if (commit) begin
            res     <= res_d;
            lane_ok <= ok_d;
        end
    end
endmodule

// File: rtl/pbsat_add_chk.sv
// Module: assertion checker bound to pbsat_add.
// Checks only at the ports, using $past, with a reset-aware guard.
module pbsat_add_chk
    import pbsat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              cond_pass,
    input logic [WORD_W-1:0] op_a,
    input logic [WORD_W-1:0] op_b,
    input logic [WORD_W-1:0] res,
    input logic [LANES-1:0]  lane_ok,
    input logic              out_valid
);
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R8
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R8
    AST_HOLD_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cond_pass) |=> ($stable(res) && $stable(lane_ok))); // R7
    AST_POS_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_pass && !op_a[7] && !op_b[7] && (op_a[7:0] + op_b[7:0] > 8'd127))
        |=> (res[7:0] == 8'h7F && !lane_ok[0])); // R3
    AST_NEG_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_pass && op_a[7] && op_b[7] && !op_a[6] && !op_b[6])
        |=> (res[7:0] == 8'h80 && !lane_ok[0])); // R4
    AST_MIXED_SIGN_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_pass && (op_a[31] != op_b[31])) |=> lane_ok[3]); // R5
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (res == '0 && lane_ok == '0 && !out_valid)); // R9
endmodule

bind pbsat_add pbsat_add_chk u_chk (.*);

// File: tb/pbsat_add_test.sv
// Bench: directed corner cases and seeded random vectors, checked against a model.
module pbsat_add_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, cond_pass;
    logic [31:0] op_a, op_b;
    logic [31:0] res;
    logic [3:0]  lane_ok;
    logic        out_valid;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] exp_res;
    logic [3:0]  exp_ok;

    always #(CLK_PERIOD/2) clk = ~clk;

    pbsat_add uut (.*);

    // Model of one lane, working on integers.
    function automatic logic [8:0] model_lane(input logic [7:0] a, input logic [7:0] b);
        int s;
        s = $signed(a) + $signed(b);
        if (s > 127)       return {8'h7F, 1'b0};
        else if (s < -128) return {8'h80, 1'b0};
        else               return {s[7:0], 1'b1};
    endfunction

    function automatic logic [35:0] model_word(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r;
        logic [3:0]  f;
        for (int i = 0; i < 4; i++) begin
            logic [8:0] t;
            t = model_lane(a[8*i +: 8], b[8*i +: 8]);
            r[8*i +: 8] = t[8:1];
            f[i] = t[0];
        end
        return {r, f};
    endfunction

    task automatic check(input string req, input logic [31:0] r, input logic [3:0] f,
                         input logic v);
        n_vec++;
        if (res !== r || lane_ok !== f || out_valid !== v) begin
            n_bad++;
            $display("FAIL %s: got res=%h ok=%b v=%b expected res=%h ok=%b v=%b",
                     req, res, lane_ok, out_valid, r, f, v);
        end
    endtask

    // Apply one operation and check it one cycle later, at the falling edge.
    task automatic apply(input string req, input logic [31:0] a, input logic [31:0] b,
                         input logic cp);
        logic [35:0] m;
        @(negedge clk);
        op_a = a; op_b = b; in_valid = 1'b1; cond_pass = cp;
        if (cp) begin
            m = model_word(a, b);
            exp_res = m[35:4];
            exp_ok  = m[3:0];
        end
        @(negedge clk);
        in_valid = 1'b0;
        check(req, exp_res, exp_ok, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5A17;
        void'($urandom(seed));
        rst_n = 1'b0; in_valid = 1'b0; cond_pass = 1'b0; op_a = '1; op_b = '1;
        exp_res = '0; exp_ok = '0;
        repeat (3) @(negedge clk);
        check("R9 reset", 32'h0, 4'h0, 1'b0);
        rst_n = 1'b1;

        // Per-lane corner: lane 0 clamps high, others untouched (R1, R3, R6).
        apply("R3 0x7F+0x01", 32'h0000_007F, 32'h0000_0001, 1'b1);
        apply("R3 0x7F+0x7F", 32'h7F7F_7F7F, 32'h7F7F_7F7F, 1'b1);
        apply("R4 0x80+0xFF", 32'h8080_8080, 32'hFFFF_FFFF, 1'b1);
        apply("R4 0x80+0x80", 32'h8080_8080, 32'h8080_8080, 1'b1);
        // Mixed lanes: overflow, underflow, in-range, exact bound (R6, R5, R1).
        apply("R6 mixed lanes", 32'h7F_80_05_70, 32'h01_FF_FD_0F, 1'b1);
        apply("R2 mixed sign", 32'h7F_80_C0_40, 32'h80_7F_40_C0, 1'b1);
        apply("R2 bounds exact", 32'h40_C0_00_FF, 32'h3F_C0_00_01, 1'b1);
        apply("R1 single lane 2", 32'h0070_0000, 32'h0070_0000, 1'b1);
        // Hold on condition fail (R7).
        apply("R7 hold", 32'h1111_1111, 32'h2222_2222, 1'b0);
        apply("R7 hold sat", 32'h7F7F_7F7F, 32'h0101_0101, 1'b0);
        // out_valid drops after single strobe (R8).
        @(negedge clk);
        check("R8 idle", exp_res, exp_ok, 1'b0);

        for (int k = 0; k < 300; k++) begin
            logic [31:0] a, b;
            a = $urandom; b = $urandom;
            apply(((k % 5) == 0) ? "R7 random hold" : "R2 random",
                  a, b, (k % 5) != 0);
        end

        // Reset mid-stream clears state (R9).
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset again", 32'h0, 4'h0, 1'b0);
        rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule